// File: doc/BRIEF.md
# Event Status Interrupt Controller with Card Detect

This block collects event flags from neighbouring logic into a 16-bit status register, filters them through a 15-bit enable mask, and drives one registered, level-sensitive interrupt line. Neighbouring blocks raise flags with one-cycle set pulses. Software clears flags by writing ones to the status register through a simple register write port. A combinational read port returns any of the registers.

The block also follows a card-detect input. The raw level is synchronised and compared with a stored detect state. A low-to-high change of the stored state counts as an insertion and raises status bit 1. The stored state is forwarded to a cover-switch output, and that output moves only when the level actually changes. Two configuration bits, a detect enable and a wake-up enable, are held here for the surrounding logic to use.

Top module: `irqdet_status_top`

## Requirements
- R1: After reset, status, mask and both detect configuration bits read 0, irq_o is 0, and cover_o equals the reset detect level (DET_INIT, default 0).
- R2: Any bit set in set_vec during a cycle is ORed into status, so it reads 1 after that clock edge.
- R3: A write to select 0 (status) clears every status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: If a set pulse (or an insertion) and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to select 1 (mask) stores write-data bits 14..0; bit 15 of the mask always reads 0.
- R6: irq_o is 1 exactly when the status AND mask held in the previous cycle is non-zero, so it follows a status or mask change one clock later.
- R7: When the synchronised detect level is 1 and the stored detect state is 0, status bit 1 is set on that edge.
- R8: A card removal (a stored detect state going from 1 to 0) sets no status bit.
- R9: card_det_i passes through SYNC_STAGES flip-flops. cover_o then takes the new level on the following edge, and cover_o changes only when the synchronised level differs from the stored state.
- R10: A write to select 2 (detect config) loads the wake-up enable from write-data bit 9 and the detect enable from bit 2. The register reads back the wake-up enable at bit 2 and the detect enable at bit 0, with every other bit 0. wake_en_o and det_en_o show the same two bits.
- R11: Select 3 reads as 0, and a write to it changes no register.
- R12: Status bit 15 cannot be enabled by the mask, so a set bit 15 by itself never raises irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_vec | input | 16 | One-cycle event set pulses from other blocks |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 status, 1 mask, 2 detect config, 3 unused |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_data | output | 16 | Combinational read data |
| card_det_i | input | 1 | Raw card-detect level |
| cover_o | output | 1 | Forwarded stored detect level |
| wake_en_o | output | 1 | Detect wake-up enable bit |
| det_en_o | output | 1 | Detect enable bit |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench targets a set and a clear landing on the same bit. A design that gave priority to the clear would lose an event that arrived in the same cycle as the acknowledge. It checks the one-cycle lag of irq_o after status and mask changes in both directions: an unregistered or doubly registered interrupt would show up as a mismatch on the exact cycle. Card-detect tests count the synchroniser stages before cover_o moves and confirm that removal is silent. A design that detected both edges, or that used the raw input, would set bit 1 on the wrong edge or at the wrong time. Bit 15 of the mask, the swapped bit positions of the detect configuration, and writes to the unused select are checked against designs that store too much or decode too loosely.

// File: rtl/irqdet_pkg.sv
package irqdet_pkg;

  localparam int STAT_W = 16;
  localparam int MASK_W = 15;

  typedef logic [STAT_W-1:0] stat_t;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_DETCFG = 2'd2,
    SEL_NONE   = 2'd3
  } sel_e;

  // clear first, then OR in sets: sets win on a shared bit
  function automatic stat_t merge_events(stat_t cur, stat_t clr, stat_t set);
    return (cur & ~clr) | set;
  endfunction

  function automatic stat_t widen_mask(logic [MASK_W-1:0] m);
    return {{(STAT_W-MASK_W){1'b0}}, m};
  endfunction

  function automatic logic any_pending(stat_t s, stat_t m);
    return |(s & m);
  endfunction

  function automatic stat_t pack_detcfg(logic wake, logic en, int unsigned wb, int unsigned eb);
    stat_t v;
    v = '0;
    v[wb] = wake;
    v[eb] = en;
    return v;
  endfunction

endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank
  import irqdet_pkg::*;
#(
  parameter int INS_BIT = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t set_vec,
  input  logic  ins_evt,
  input  stat_t clr_vec,
  output stat_t status_q
);

  stat_t set_all;
  stat_t status_d;

  always_comb begin
    set_all  = set_vec | (stat_t'(ins_evt) << INS_BIT);
    status_d = merge_events(status_q, clr_vec, set_all);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irqdet_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [MASK_W-1:0] mask_wdata,
  input  stat_t             status_q,
  output stat_t             mask_full,
  output logic              irq_q
);

  logic [MASK_W-1:0] mask_q;

  assign mask_full = widen_mask(mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      irq_q <= any_pending(status_q, mask_full);
    end
  end

endmodule

// File: rtl/card_det_track.sv
module card_det_track #(
  parameter int SYNC_STAGES = 2,
  parameter bit DET_INIT    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_raw,
  input  logic cfg_we,
  input  logic cfg_wake,
  input  logic cfg_en,
  output logic det_sync,
  output logic det_state,
  output logic cover_q,
  output logic ins_evt,
  output logic wake_en,
  output logic det_en
);

  logic [SYNC_STAGES-1:0] chain;
  logic                   lvl_change;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= DET_INIT;
        else        chain <= det_raw;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {SYNC_STAGES{DET_INIT}};
        else        chain <= {chain[SYNC_STAGES-2:0], det_raw};
      end
    end
  endgenerate

  assign det_sync   = chain[SYNC_STAGES-1];
  assign lvl_change = det_sync ^ det_state;
  assign ins_evt    = det_sync & ~det_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_state <= DET_INIT;
      cover_q   <= DET_INIT;
      wake_en   <= 1'b0;
      det_en    <= 1'b0;
    end else begin
      if (lvl_change) begin
        det_state <= det_sync;
        cover_q   <= det_sync;
      end
      if (cfg_we) begin
        wake_en <= cfg_wake;
        det_en  <= cfg_en;
      end
    end
  end

endmodule

// File: rtl/irqdet_status_top.sv
module irqdet_status_top
  import irqdet_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit DET_INIT    = 1'b0,
  parameter int INS_BIT     = 1,
  parameter int WAKE_WR_BIT = 9,
  parameter int EN_WR_BIT   = 2,
  parameter int WAKE_RD_BIT = 2,
  parameter int EN_RD_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [STAT_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [STAT_W-1:0] rd_data,
  input  logic              card_det_i,
  output logic              cover_o,
  output logic              wake_en_o,
  output logic              det_en_o,
  output logic              irq_o
);

  stat_t status_q;
  stat_t mask_full;
  stat_t clr_vec;
  logic  stat_we, mask_we, cfg_we;
  logic  det_sync, det_state, ins_evt;

  always_comb begin
    stat_we = wr_en && (sel_e'(wr_sel) == SEL_STATUS);
    mask_we = wr_en && (sel_e'(wr_sel) == SEL_MASK);
    cfg_we  = wr_en && (sel_e'(wr_sel) == SEL_DETCFG);
    clr_vec = stat_we ? wr_data : '0;
  end

  evt_status_bank #(.INS_BIT(INS_BIT)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .ins_evt  (ins_evt),
    .clr_vec  (clr_vec),
    .status_q (status_q)
  );

  irq_mask_unit u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_we    (mask_we),
    .mask_wdata (wr_data[MASK_W-1:0]),
    .status_q   (status_q),
    .mask_full  (mask_full),
    .irq_q      (irq_o)
  );

  card_det_track #(.SYNC_STAGES(SYNC_STAGES), .DET_INIT(DET_INIT)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .det_raw   (card_det_i),
    .cfg_we    (cfg_we),
    .cfg_wake  (wr_data[WAKE_WR_BIT]),
    .cfg_en    (wr_data[EN_WR_BIT]),
    .det_sync  (det_sync),
    .det_state (det_state),
    .cover_q   (cover_o),
    .ins_evt   (ins_evt),
    .wake_en   (wake_en_o),
    .det_en    (det_en_o)
  );

  always_comb begin
    case (sel_e'(rd_sel))
      SEL_STATUS: rd_data = status_q;
      SEL_MASK:   rd_data = mask_full;
      SEL_DETCFG: rd_data = pack_detcfg(wake_en_o, det_en_o, WAKE_RD_BIT, EN_RD_BIT);
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/irqdet_checker.sv
module irqdet_checker
  import irqdet_pkg::*;
#(
  parameter int INS_BIT = 1
) (
  input logic  clk,
  input logic  rst_n,
  input stat_t set_vec,
  input logic  wr_en,
  input logic [1:0] wr_sel,
  input stat_t wr_data,
  input stat_t status_q,
  input stat_t mask_full,
  input logic  irq_o,
  input logic  cover_o,
  input logic  det_sync,
  input logic  det_state,
  input logic  ins_evt
);

  stat_t ins_vec;
  assign ins_vec = stat_t'(ins_evt) << INS_BIT;

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> ((status_q & $past(wr_data & ~set_vec & ~ins_vec)) == '0)); // R3

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(set_vec) & ~$past(ins_vec)) == '0)); // R8

  AST_IRQ_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == (|($past(status_q) & $past(mask_full))))); // R6

  AST_INS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ins_evt |=> status_q[INS_BIT]); // R7

  AST_COVER_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (det_sync == det_state) |=> $stable(cover_o)); // R9

  AST_TOP_BIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 16'h8000) |=> !irq_o); // R12

endmodule

bind irqdet_status_top irqdet_checker #(.INS_BIT(INS_BIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .set_vec   (set_vec),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .status_q  (status_q),
  .mask_full (mask_full),
  .irq_o     (irq_o),
  .cover_o   (cover_o),
  .det_sync  (det_sync),
  .det_state (det_state),
  .ins_evt   (ins_evt)
);

// File: tb/sim_irqdet_status_top.sv
`timescale 1ns/100ps
module sim_irqdet_status_top;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] set_vec = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        card_det_i = 1'b0;
  logic        cover_o, wake_en_o, det_en_o, irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  bit run_cmp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqdet_status_top #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .card_det_i(card_det_i),
    .cover_o(cover_o), .wake_en_o(wake_en_o), .det_en_o(det_en_o), .irq_o(irq_o)
  );

  // behavioural reference model
  logic [15:0] m_status, m_mask;
  bit m_irq, m_det, m_cover, m_wake, m_en;
  bit hist[$];

  always @(posedge clk or negedge rst_n) begin : model
    bit cur, ins, nirq;
    logic [15:0] clr, nst;
    if (!rst_n) begin
      m_status = '0; m_mask = '0; m_irq = 0; m_det = 0; m_cover = 0;
      m_wake = 0; m_en = 0;
      hist = {};
      repeat (SYNC) hist.push_back(1'b0);
    end else begin
      cur  = hist[0];
      ins  = cur && !m_det;
      nirq = (m_status & m_mask) != 0;
      clr  = (wr_en && wr_sel == 2'd0) ? wr_data : 16'h0;
      nst  = (m_status & ~clr) | set_vec;
      if (ins) nst[1] = 1'b1;
      if (wr_en && wr_sel == 2'd1) m_mask = {1'b0, wr_data[14:0]};
      if (wr_en && wr_sel == 2'd2) begin m_wake = wr_data[9]; m_en = wr_data[2]; end
      if (cur != m_det) begin m_det = cur; m_cover = cur; end
      m_status = nst;
      m_irq = nirq;
      void'(hist.pop_front());
      hist.push_back(card_det_i);
    end
  end

  function automatic logic [15:0] exp_rd(logic [1:0] s);
    case (s)
      2'd0: return m_status;
      2'd1: return m_mask;
      2'd2: return {13'b0, m_wake, 1'b0, m_en};
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(negedge clk);
    #(CLK_PERIOD/8.0);
    if (rst_n && run_cmp) begin
      chk("R6 irq", {15'b0, irq_o}, {15'b0, m_irq});
      chk("R9 cover", {15'b0, cover_o}, {15'b0, m_cover});
      chk("R10 enables", {14'b0, wake_en_o, det_en_o}, {14'b0, m_wake, m_en});
      case (rd_sel)
        2'd0: chk("R3 status read", rd_data, exp_rd(rd_sel));
        2'd1: chk("R5 mask read", rd_data, exp_rd(rd_sel));
        2'd2: chk("R10 cfg read", rd_data, exp_rd(rd_sel));
        default: chk("R11 unused read", rd_data, exp_rd(rd_sel));
      endcase
    end
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected below %0d", cycles, WATCHDOG);
      report();
    end
  end

  task automatic put(logic [15:0] s, bit we, logic [1:0] sel, logic [15:0] d);
    @(negedge clk);
    set_vec = s; wr_en = we; wr_sel = sel; wr_data = d;
    @(negedge clk);
    set_vec = '0; wr_en = 1'b0;
  endtask

  task automatic look();
    #(CLK_PERIOD/4.0);
  endtask

  task automatic peek(logic [1:0] sel, output logic [15:0] v);
    rd_sel = sel;
    #0.5;
    v = rd_data;
  endtask

  initial begin : main
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look();
    peek(2'd0, v); chk("R1 status", v, 16'h0);
    peek(2'd1, v); chk("R1 mask", v, 16'h0);
    peek(2'd2, v); chk("R1 cfg", v, 16'h0);
    chk("R1 irq/cover", {14'b0, irq_o, cover_o}, 16'h0);
    run_cmp = 1;

    put(16'h0081, 0, 2'd0, 16'h0); look();
    peek(2'd0, v); chk("R2 set", v, 16'h0081);
    chk("R6 masked off", {15'b0, irq_o}, 16'h0);

    put(16'h0, 1, 2'd1, 16'hffff); look();
    peek(2'd1, v); chk("R5 mask bit15", v, 16'h7fff);
    chk("R6 lag rise", {15'b0, irq_o}, 16'h0);
    @(negedge clk); look();
    chk("R6 rise", {15'b0, irq_o}, 16'h1);

    put(16'h0, 1, 2'd0, 16'h0001); look();
    peek(2'd0, v); chk("R3 w1c", v, 16'h0080);

    put(16'h0080, 1, 2'd0, 16'h0080); look();
    peek(2'd0, v); chk("R4 set wins", v, 16'h0080);

    put(16'h0, 1, 2'd0, 16'hffff); look();
    peek(2'd0, v); chk("R3 clear all", v, 16'h0);
    chk("R6 lag fall", {15'b0, irq_o}, 16'h1);
    @(negedge clk); look();
    chk("R6 fall", {15'b0, irq_o}, 16'h0);

    put(16'h8000, 0, 2'd0, 16'h0);
    @(negedge clk); look();
    peek(2'd0, v); chk("R12 bit15 set", v, 16'h8000);
    chk("R12 no irq", {15'b0, irq_o}, 16'h0);
    put(16'h0, 1, 2'd0, 16'h8000);

    put(16'h0, 1, 2'd2, 16'h0204); look();
    peek(2'd2, v); chk("R10 both", v, 16'h0005);
    chk("R10 pins", {14'b0, wake_en_o, det_en_o}, 16'h0003);
    put(16'h0, 1, 2'd2, 16'h0200); look();
    peek(2'd2, v); chk("R10 wake only", v, 16'h0004);
    put(16'h0, 1, 2'd2, 16'hfdfb); look();
    peek(2'd2, v); chk("R10 other bits", v, 16'h0000);

    put(16'h0, 1, 2'd3, 16'hffff); look();
    peek(2'd3, v); chk("R11 read", v, 16'h0);
    peek(2'd0, v); chk("R11 status kept", v, 16'h0);
    peek(2'd1, v); chk("R11 mask kept", v, 16'h7fff);
    peek(2'd2, v); chk("R11 cfg kept", v, 16'h0);

    @(negedge clk); card_det_i = 1'b1;
    repeat (SYNC) @(negedge clk);
    look();
    chk("R9 not yet", {15'b0, cover_o}, 16'h0);
    @(negedge clk); look();
    chk("R9 cover up", {15'b0, cover_o}, 16'h1);
    peek(2'd0, v); chk("R7 insertion", v, 16'h0002);
    put(16'h0, 1, 2'd0, 16'h0002);
    card_det_i = 1'b0;
    repeat (SYNC + 1) @(negedge clk);
    look();
    chk("R9 cover down", {15'b0, cover_o}, 16'h0);
    peek(2'd0, v); chk("R8 removal silent", v, 16'h0);

    repeat (3000) begin
      @(negedge clk);
      set_vec    = ($urandom_range(7) == 0) ? 16'($urandom) : 16'h0;
      wr_en      = ($urandom_range(3) == 0);
      wr_sel     = 2'($urandom_range(3));
      wr_data    = 16'($urandom);
      rd_sel     = 2'($urandom_range(3));
      if ($urandom_range(15) == 0) card_det_i = ~card_det_i;
    end
    @(negedge clk);
    set_vec = '0; wr_en = 1'b0;
    repeat (4) @(negedge clk);
    done = 1;
    report();
  end

endmodule